// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects up to 31 interrupt requests and drives one active-low request line to a processor. Each source is set up through its own configuration word, which holds a 3-bit priority (7 highest, 0 lowest) and a flag that picks rising-edge or level triggering. Sources are switched on and off through separate set and clear command words. Input 0 is reserved and never raises a request.

The request line falls as soon as an enabled source becomes pending at a priority the controller will accept. The controller does not pick a winner when the line falls. It picks one when software reads the vector word. The read returns the winner's programmed 32-bit vector and counts as the acknowledge. The winner's number is latched into a readable current-source word. Its priority is pushed onto an 8-deep level stack.

While a service is open, only a strictly higher priority can pull the line low again. An end-of-service write pops the stack and restores the previous level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the request output is high, the level stack is empty, the current-source word reads 0, the enable mask reads 0 and every configuration word reads 0.
- R2: Configuration word i (address i, 1 to 31) holds the priority in bits [2:0] and the trigger flag in bit 5 (1 = rising edge, 0 = level). A read returns the written value in those bits.
- R3: Writing a bit mask to address 0x42 enables the marked sources, and writing one to address 0x43 disables them. Reading address 0x42 returns the mask, where bit 0 always reads 0. A disabled source never pulls the request output low.
- R4: Once an enabled source becomes active with no service open, the request output falls within 3 clock cycles for a level source and within 4 clock cycles for an edge source.
- R5: A read of address 0x40 returns the vector (addresses 0x20+i) of the pending enabled source with the highest priority. Ties go to the lowest source number. The choice is made at the read, so it includes sources that became pending after the request output fell.
- R6: A vector read that selects a source acknowledges it. The source number becomes readable at address 0x41, and the source's priority becomes the current level.
- R7: An edge source stays pending from its rising edge until it is acknowledged. A level source is pending whenever its input is high, including after it has been acknowledged.
- R8: While a service is open, the request output falls only for a pending source whose priority is strictly above the current level.
- R9: Any write to address 0x44 ends the current service and restores the level that was current before it. With no service open, the write has no effect.
- R10: A vector read when no source is eligible returns 0 and leaves the current source, the level stack and the pending state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| src_in | input | 32 | Raw interrupt request inputs |
| irq_n | output | 1 | Active-low request to the processor |

## Verification
The assertions assume that each bus cycle carries at most one access and that read and write strobes are never raised together. Under that assumption, an acknowledge and an end-of-service write never fall in the same cycle. They also assume the stack cannot overflow, because each push is strictly higher in priority than the one below it. The bench issues one access per task call and acknowledges only through the vector read. It raises every source input from a task, one clock after an edge. Sources are kept steady across each vector read, so the winner the bench expects is settled before the read.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NSRC  = 32,
  parameter int DEPTH = 8,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic          irq_n
);
  localparam int IW = $clog2(NSRC);
  localparam int DW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_VEC  = AW'(NSRC);
  localparam logic [AW-1:0] A_IVR  = AW'(2*NSRC);
  localparam logic [AW-1:0] A_CUR  = AW'(2*NSRC + 1);
  localparam logic [AW-1:0] A_EN   = AW'(2*NSRC + 2);
  localparam logic [AW-1:0] A_DIS  = AW'(2*NSRC + 3);
  localparam logic [AW-1:0] A_EOI  = AW'(2*NSRC + 4);

  logic [2:0]      prio  [NSRC];
  logic            etype [NSRC];
  logic [31:0]     vec   [NSRC];
  logic [2:0]      stk   [DEPTH];
  logic [NSRC-1:0] en, src_q, src_d, epend, pend, etype_v;
  logic [DW-1:0]   depth;
  logic [IW-1:0]   cur_src, win_idx;
  logic [2:0]      win_prio, cur_lvl;
  logic            win_ok, elig, ack, eoi, irq_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_type
    assign etype_v[g] = etype[g];
  end

  assign pend    = ((epend & etype_v) | (src_q & ~etype_v)) & en;
  assign cur_lvl = (depth != 0) ? stk[depth - DW'(1)] : 3'd0;
  assign elig    = win_ok && (depth == 0 || win_prio > cur_lvl);
  assign ack     = bus_rd && bus_addr == A_IVR && elig;
  assign eoi     = bus_wr && bus_addr == A_EOI;
  assign irq_n   = irq_q;

  always_comb begin
    win_ok = 1'b0; win_idx = '0; win_prio = '0;
    for (int i = NSRC - 1; i >= 1; i--)
      if (pend[i] && (!win_ok || prio[i] >= win_prio)) begin
        win_ok = 1'b1; win_idx = IW'(i); win_prio = prio[i];
      end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_VEC)
      bus_rdata = {26'd0, etype[bus_addr[IW-1:0]], 2'd0, prio[bus_addr[IW-1:0]]};
    else if (bus_addr < A_IVR)
      bus_rdata = vec[bus_addr[IW-1:0]];
    else if (bus_addr == A_IVR)
      bus_rdata = elig ? vec[win_idx] : 32'd0;
    else if (bus_addr == A_CUR)
      bus_rdata = 32'(cur_src);
    else if (bus_addr == A_EN)
      bus_rdata = 32'(en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0; src_d <= '0; epend <= '0; en <= '0;
      depth <= '0; cur_src <= '0; irq_q <= 1'b1;
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0; etype[i] <= 1'b0; vec[i] <= '0;
      end
      for (int i = 0; i < DEPTH; i++) stk[i] <= '0;
    end else begin
      src_q <= src_in;
      src_d <= src_q;
      irq_q <= !elig;
      for (int i = 0; i < NSRC; i++)
        if (src_q[i] && !src_d[i]) epend[i] <= 1'b1;
        else if (ack && win_idx == IW'(i)) epend[i] <= 1'b0;
      if (bus_wr) begin
        if (bus_addr < A_VEC) begin
          prio[bus_addr[IW-1:0]]  <= bus_wdata[2:0];
          etype[bus_addr[IW-1:0]] <= bus_wdata[5];
        end else if (bus_addr < A_IVR)
          vec[bus_addr[IW-1:0]] <= bus_wdata;
        else if (bus_addr == A_EN)
          en <= (en | bus_wdata[NSRC-1:0]) & ~NSRC'(1);
        else if (bus_addr == A_DIS)
          en <= en & ~bus_wdata[NSRC-1:0];
      end
      if (ack) begin
        stk[depth[$clog2(DEPTH)-1:0]] <= win_prio;
        depth   <= depth + DW'(1);
        cur_src <= win_idx;
      end else if (eoi && depth != 0)
        depth <= depth - DW'(1);
    end
  end
endmodule

module prio_irq_ctrl_chk #(parameter int NSRC = 32, parameter int DW = 4) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            eoi,
  input logic            irq_n,
  input logic [NSRC-1:0] en,
  input logic [DW-1:0]   depth,
  input logic [$clog2(NSRC)-1:0] win_idx,
  input logic [$clog2(NSRC)-1:0] cur_src,
  input logic [2:0]      win_prio,
  input logic [2:0]      cur_lvl
);
  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> irq_n);
  assert_ack_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> depth == $past(depth) + DW'(1));
  assert_ack_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cur_src == $past(win_idx));
  assert_ack_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> cur_lvl == $past(win_prio));
  assert_eoi_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && depth != 0) |=> depth == $past(depth) - DW'(1));
  assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && depth == 0) |=> depth == 0);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(8));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.NSRC(NSRC), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ack(ack), .eoi(eoi), .irq_n(irq_n), .en(en),
  .depth(depth), .win_idx(win_idx), .cur_src(cur_src),
  .win_prio(win_prio), .cur_lvl(cur_lvl));

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb_top;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, src_in = '0;
  logic irq_n;
  int checks = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  prio_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_n(irq_n));

  always @(negedge clk) if (bus_rd && exp_q.size() > 0) begin
    logic [31:0] e;
    string t;
    e = exp_q.pop_front(); t = tag_q.pop_front();
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s: read got %h expected %h", t, bus_rdata, e);
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_rd = 1; bus_addr = a;
    @(posedge clk); #1 bus_rd = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_n !== e) begin
      fails++;
      $display("FAIL %s: irq_n got %b expected %b", t, irq_n, e);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk_irq(1, "R1");
    rd(7'h41, 0, "R1"); rd(7'h42, 0, "R1"); rd(7'h03, 0, "R1");
    wr(7'h03, 32'h02); wr(7'h05, 32'h25); wr(7'h06, 32'h05); wr(7'h09, 32'h07);
    for (int i = 1; i < 32; i++) wr(7'(32 + i), 32'h1000 + i);
    rd(7'h05, 32'h25, "R2");
    src_in[3] = 1; cyc(5);
    chk_irq(1, "R3 disabled");
    wr(7'h42, 32'h9); cyc(3);
    chk_irq(0, "R4 level");
    rd(7'h42, 32'h8, "R3 mask");
    rd(7'h40, 32'h1003, "R5");
    rd(7'h41, 3, "R6");
    cyc(3); chk_irq(1, "R8 equal waits");
    wr(7'h42, 32'h60);
    src_in[5] = 1; cyc(1); src_in[5] = 0; src_in[6] = 1;
    cyc(4); chk_irq(0, "R4 edge / R8 higher");
    rd(7'h40, 32'h1005, "R5 tie");
    rd(7'h41, 5, "R6");
    cyc(3); chk_irq(1, "R8 equal level");
    wr(7'h44, 0); cyc(3);
    chk_irq(0, "R9 restore");
    rd(7'h40, 32'h1006, "R7 edge cleared");
    src_in[6] = 0; wr(7'h44, 0);
    src_in[9] = 1; wr(7'h42, 32'h200); cyc(4);
    chk_irq(0, "R8 top");
    rd(7'h40, 32'h1009, "R5 highest");
    src_in[9] = 0;
    wr(7'h44, 0); wr(7'h44, 0); wr(7'h44, 0); cyc(3);
    chk_irq(0, "R9 empty pop");
    rd(7'h40, 32'h1003, "R7 level stays");
    cyc(3); chk_irq(1, "R8");
    rd(7'h40, 0, "R10");
    rd(7'h41, 3, "R10 cur kept");
    wr(7'h44, 0); cyc(3);
    chk_irq(0, "R10 state kept");
    wr(7'h43, 32'h8); cyc(3);
    chk_irq(1, "R3 disable");
    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule